// File: doc/BRIEF.md
# Audio Delay-Line Sequencer for SPI RAM and DAC

This block turns one or two external byte-wide SPI RAM chips into a circular audio delay line. On each sample tick it runs one fixed sequence over a single SPI master bus. It fetches an older sample from RAM, passes that sample to an SPI DAC, and stores the newest ADC sample at the advanced write pointer. The read position trails the write pointer by a delay. That delay comes from an 8-bit knob reading, scaled down by a power of two that a 3-bit range code and the RAM count select.

After reset the block puts every RAM into byte access mode before it accepts any tick. The sample-rate timer and the ADC sit outside the block. They appear as a one-cycle `tick` and an 8-bit `sample_in`. A tick that arrives while a sequence is still running is dropped and reported on `overrun`.

Top module: `spi_delay_line`

## Requirements
- R1: After reset, before any tick is served, the block sends two 16-bit frames. The first is 0x01 then 0x01 with `cs_ram0_n` low. The second is the same two bytes with `cs_ram1_n` low.
- R2: A read frame is 32 bits: byte 0x03, then the read address high byte, then the low byte, then 0xFF. The sample is taken from `miso` during the final byte.
- R3: The read address is the 16-bit write pointer minus the 16-bit delay, modulo 2^16. Reset clears both the write pointer and the delay to zero.
- R4: Each tick served yields exactly three frames in this order: read, DAC, write. The write pointer rises by exactly one between the read and the write.
- R5: The DAC frame is 16 bits sent with `cs_dac_n` low: 4'b0011, then the 8 bits read from RAM, then 4'b0000.
- R6: A write frame is 32 bits: byte 0x02, then the incremented write pointer high byte and low byte, then the `sample_in` value captured at the tick.
- R7: The delay is {knob, 8'h00}. With `dual_ram` low it is first shifted right by one. It is then shifted right by `range_sel` places, so code 7 gives the shortest delay.
- R8: With `dual_ram` high at the tick, address bit 15 selects RAM1 when set and RAM0 when clear, for both reads and writes. With `dual_ram` low, every access uses RAM0.
- R9: The SPI bus runs in mode 0 and sends MSB first. At most one chip select is low at a time, and each stays low for a whole frame. All chip selects go high for at least one cycle between frames. `sck` is low whenever no chip select is low.
- R10: The new delay is latched when the write frame ends and applies from the next tick. The first tick after reset reads with a delay of zero.
- R11: A tick that arrives while the init frames or a sequence are running causes `overrun` to be high for the following cycle. That tick is otherwise ignored: no extra frames are sent and the captured sample is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample-period strobe |
| sample_in | input | 8 | Newest ADC sample |
| knob | input | 8 | Delay knob reading |
| range_sel | input | 3 | Extra right-shift count for the delay |
| dual_ram | input | 1 | High when two RAM chips are fitted |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI data to the slaves |
| miso | input | 1 | SPI data from the RAMs |
| cs_ram0_n | output | 1 | Chip select of RAM0, active low |
| cs_ram1_n | output | 1 | Chip select of RAM1, active low |
| cs_dac_n | output | 1 | Chip select of the DAC, active low |
| overrun | output | 1 | Pulses when a tick is dropped |

## Verification
The bench decodes every frame on the bus and compares it with a reference model of pointer and delay. In that model the RAM answers with a byte derived from the address, so a wrong read address shows up in the DAC frame as well as in the read frame.

Directed periods cover several cases. A zero-delay first tick exposes an early delay latch. A knob of 0x80 with full range in dual mode sets address bit 15 and so separates RAM1 from RAM0. The same knob in single mode must stay on RAM0 and show the extra halving.

Seeded random periods mix all range codes, both RAM counts and arbitrary samples to check the scaling and the wraparound. One run injects a tick in the middle of a sequence with a different sample present. It shows whether the extra tick is flagged, whether it leaks into the stored byte, and whether it spawns extra frames.

// File: rtl/spi_delay_line.sv
module spi_delay_line #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] sample_in,
  input  logic [7:0] knob,
  input  logic [2:0] range_sel,
  input  logic       dual_ram,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_ram0_n,
  output logic       cs_ram1_n,
  output logic       cs_dac_n,
  output logic       overrun
);

  localparam int DIVW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(SCK_HALF - 1);
  localparam logic [1:0] SEL_R0  = 2'd0;
  localparam logic [1:0] SEL_R1  = 2'd1;
  localparam logic [1:0] SEL_DAC = 2'd2;

  typedef enum logic [2:0] {S_INIT0, S_INIT1, S_IDLE, S_RD, S_DAC, S_WR} state_t;

  state_t         state;
  logic           active;
  logic [1:0]     cs_sel;
  logic [31:0]    sreg;
  logic [5:0]     bits;
  logic [DIVW-1:0] div;
  logic [7:0]     rx, rd_q, smp;
  logic [15:0]    wp, dly;
  logic           cfg_dual;

  logic [15:0]    rd_addr, dly_base, dly_next;
  logic [31:0]    f_word;
  logic [5:0]     f_len;
  logic [1:0]     f_cs;
  logic           launch, bit_end, frame_end;

  assign rd_addr   = wp - dly;
  assign dly_base  = cfg_dual ? {knob, 8'h00} : {1'b0, knob, 7'h00};
  assign dly_next  = dly_base >> range_sel;
  assign launch    = !active && state != S_IDLE;
  assign bit_end   = active && div == DIV_LAST && sck;
  assign frame_end = bit_end && bits == 6'd1;

  always_comb begin
    case (state)
      S_INIT0: begin f_word = {16'h0101, 16'h0000}; f_len = 6'd16; f_cs = SEL_R0; end
      S_INIT1: begin f_word = {16'h0101, 16'h0000}; f_len = 6'd16; f_cs = SEL_R1; end
      S_RD:    begin
        f_word = {8'h03, rd_addr, 8'hFF}; f_len = 6'd32;
        f_cs   = (cfg_dual && rd_addr[15]) ? SEL_R1 : SEL_R0;
      end
      S_DAC:   begin f_word = {4'b0011, rd_q, 4'b0000, 16'h0000}; f_len = 6'd16; f_cs = SEL_DAC; end
      default: begin
        f_word = {8'h02, wp, smp}; f_len = 6'd32;
        f_cs   = (cfg_dual && wp[15]) ? SEL_R1 : SEL_R0;
      end
    endcase
  end

  assign mosi      = active & sreg[31];
  assign cs_ram0_n = !(active && cs_sel == SEL_R0);
  assign cs_ram1_n = !(active && cs_sel == SEL_R1);
  assign cs_dac_n  = !(active && cs_sel == SEL_DAC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_INIT0;
      active   <= 1'b0;
      cs_sel   <= SEL_R0;
      sreg     <= '0;
      bits     <= '0;
      div      <= '0;
      sck      <= 1'b0;
      rx       <= '0;
      rd_q     <= '0;
      smp      <= '0;
      wp       <= '0;
      dly      <= '0;
      cfg_dual <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= tick && state != S_IDLE;
      if (state == S_IDLE && tick) begin
        state    <= S_RD;
        smp      <= sample_in;
        cfg_dual <= dual_ram;
      end
      if (launch) begin
        active <= 1'b1;
        sreg   <= f_word;
        bits   <= f_len;
        cs_sel <= f_cs;
        div    <= '0;
        sck    <= 1'b0;
      end else if (active) begin
        if (div == DIV_LAST) begin
          div <= '0;
          sck <= !sck;
          if (!sck) begin
            rx <= {rx[6:0], miso};
          end else begin
            sreg <= {sreg[30:0], 1'b0};
            bits <= bits - 6'd1;
          end
        end else begin
          div <= div + DIVW'(1);
        end
        if (frame_end) begin
          active <= 1'b0;
          case (state)
            S_INIT0: state <= S_INIT1;
            S_INIT1: state <= S_IDLE;
            S_RD:    begin state <= S_DAC; rd_q <= rx; wp <= wp + 16'd1; end
            S_DAC:   state <= S_WR;
            default: begin state <= S_IDLE; dly <= dly_next; end
          endcase
        end
      end
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cs_ram0_n, cs_ram1_n, cs_dac_n}) >= 2) else $error("cs"); // R9
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_ram0_n && cs_ram1_n && cs_dac_n) |-> !sck) else $error("sck"); // R9
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi"); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp) |-> wp == $past(wp) + 16'd1) else $error("wp"); // R4
  AST_DELAY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly) |-> $past(state) == S_WR && state == S_IDLE) else $error("dly"); // R10
  AST_NO_EXTRA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == S_DAC) |=> state != S_RD) else $error("ovr"); // R11

endmodule

// File: tb/sim_spi_delay_line.sv
module sim_spi_delay_line;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, dual_ram = 0, miso = 0;
  logic [7:0] sample_in = 0, knob = 0;
  logic [2:0] range_sel = 0;
  logic sck, mosi, cs_ram0_n, cs_ram1_n, cs_dac_n, overrun;

  int checks = 0, errors = 0;
  logic [15:0] wp_m = 0, dly_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_delay_line u0 (.clk, .rst_n, .tick, .sample_in, .knob, .range_sel, .dual_ram,
                     .sck, .mosi, .miso, .cs_ram0_n, .cs_ram1_n, .cs_dac_n, .overrun);

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
  endfunction

  function automatic logic [15:0] dly_fn(input logic [7:0] k, input logic [2:0] r, input logic d);
    logic [15:0] b;
    b = d ? {k, 8'h00} : ({k, 8'h00} >> 1);
    return b >> r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus monitor and RAM model
  logic [39:0] fq[$];
  logic p_sck = 0;
  logic [2:0] p_cs = 3'b111;
  int nb = 0, multi_sel = 0, sck_bad = 0;
  logic [31:0] sh = 0;
  logic [15:0] addr_cap = 0;
  logic [1:0] who = 0;

  always @(negedge clk) begin
    logic [2:0] cs_now;
    logic [7:0] rv;
    cs_now = {cs_dac_n, cs_ram1_n, cs_ram0_n};
    if (!rst_n) begin
      p_sck = 0; p_cs = 3'b111; nb = 0; miso = 0;
    end else begin
      if ($countones(cs_now) < 2) multi_sel++;
      if (cs_now == 3'b111 && sck) sck_bad++;
      if (p_cs == 3'b111 && cs_now != 3'b111) begin
        nb = 0; sh = 0;
        who = !cs_now[0] ? 2'd0 : (!cs_now[1] ? 2'd1 : 2'd2);
      end
      if (cs_now != 3'b111 && !p_sck && sck) begin
        sh = {sh[30:0], mosi}; nb++;
        if (nb == 24) addr_cap = sh[15:0];
      end
      if (cs_now != 3'b111 && p_sck && !sck && nb >= 24 && nb < 32) begin
        rv = rd_fn(addr_cap);
        miso = rv[31 - nb];
      end
      if (p_cs != 3'b111 && cs_now == 3'b111) fq.push_back({who, 6'(nb), sh});
      p_sck = sck; p_cs = cs_now;
    end
  end

  task automatic wait_frames(input int n);
    for (int i = 0; i < 5000 && fq.size() < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic check_period(input logic [7:0] k, input logic [2:0] r, input logic d,
                              input logic [7:0] s, input string tag);
    logic [39:0] f;
    logic [15:0] ra;
    logic [1:0] bank;
    wait_frames(3);
    chk(fq.size() == 3, {tag, " R4 frame count"}, fq.size(), 3);
    ra = wp_m - dly_m;
    bank = (d && ra[15]) ? 2'd1 : 2'd0;
    f = (fq.size() > 0) ? fq.pop_front() : 40'h0;
    chk(f == {bank, 6'd32, 8'h03, ra, 8'hFF}, {tag, " R2 R3 R8 read frame"}, f, {bank, 6'd32, 8'h03, ra, 8'hFF});
    f = (fq.size() > 0) ? fq.pop_front() : 40'h0;
    chk(f == {2'd2, 6'd16, 16'h0, 4'b0011, rd_fn(ra), 4'b0000}, {tag, " R5 dac frame"},
        f, {2'd2, 6'd16, 16'h0, 4'b0011, rd_fn(ra), 4'b0000});
    wp_m = wp_m + 16'd1;
    bank = (d && wp_m[15]) ? 2'd1 : 2'd0;
    f = (fq.size() > 0) ? fq.pop_front() : 40'h0;
    chk(f == {bank, 6'd32, 8'h02, wp_m, s}, {tag, " R6 R4 R8 write frame"}, f, {bank, 6'd32, 8'h02, wp_m, s});
    dly_m = dly_fn(k, r, d);
    fq.delete();
  endtask

  task automatic period(input logic [7:0] k, input logic [2:0] r, input logic d,
                        input logic [7:0] s, input string tag);
    @(negedge clk);
    knob = k; range_sel = r; dual_ram = d; sample_in = s;
    pulse_tick();
    check_period(k, r, d, s, tag);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [39:0] f;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk({cs_ram0_n, cs_ram1_n, cs_dac_n, sck, overrun} == 5'b11100, "R9 reset idle",
        {cs_ram0_n, cs_ram1_n, cs_dac_n, sck, overrun}, 5'b11100);
    rst_n = 1;
    wait_frames(2);
    f = (fq.size() > 0) ? fq.pop_front() : 40'h0;
    chk(f == {2'd0, 6'd16, 32'h0101}, "R1 init RAM0", f, {2'd0, 6'd16, 32'h0101});
    f = (fq.size() > 0) ? fq.pop_front() : 40'h0;
    chk(f == {2'd1, 6'd16, 32'h0101}, "R1 init RAM1", f, {2'd1, 6'd16, 32'h0101});
    repeat (4) @(negedge clk);

    // R10: first period reads with zero delay despite large knob
    period(8'hFF, 3'd0, 1'b1, 8'h3C, "R10 first");
    // R8: dual, delay 0x8000 -> read address bit 15 set -> RAM1
    period(8'h80, 3'd0, 1'b1, 8'h11, "R8 dual pre");
    period(8'h80, 3'd0, 1'b1, 8'h22, "R8 dual hi");
    // R7 R8: single, 0x80 knob -> 0x4000, still RAM0 with bit 15 set
    period(8'h80, 3'd0, 1'b0, 8'h33, "R7 single pre");
    period(8'h80, 3'd7, 1'b0, 8'h44, "R8 single hi");
    period(8'hFF, 3'd7, 1'b1, 8'h55, "R7 range7");

    for (int i = 0; i < 30; i++) begin
      period(8'($urandom), 3'($urandom), 1'($urandom), 8'($urandom), "R7 random");
    end

    // R11: tick during a running period
    @(negedge clk);
    knob = 8'h10; range_sel = 3'd2; dual_ram = 1'b1; sample_in = 8'h9A;
    pulse_tick();
    chk(overrun == 1'b0, "R11 no overrun on idle tick", overrun, 0);
    repeat (20) @(negedge clk);
    sample_in = 8'hEE;
    tick = 1;
    @(negedge clk);
    tick = 0;
    chk(overrun == 1'b1, "R11 overrun raised", overrun, 1);
    @(negedge clk);
    chk(overrun == 1'b0, "R11 overrun one cycle", overrun, 0);
    check_period(8'h10, 3'd2, 1'b1, 8'h9A, "R11 kept sample");
    repeat (300) @(negedge clk);
    chk(fq.size() == 0, "R11 no extra frames", fq.size(), 0);
    period(8'h01, 3'd1, 1'b0, 8'h77, "R3 after overrun");

    chk(multi_sel == 0, "R9 single chip select", multi_sel, 0);
    chk(sck_bad == 0, "R9 sck low between frames", sck_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule